// File: doc/BRIEF.md
# Bitmap Transport Stream PID Filter

The block screens 188-byte MPEG transport stream packets on two independent byte-wide lanes. Each lane owns a 8192-entry drop map, one bit per 13-bit packet identifier (PID), stored as 1024 bytes. A lane takes the PID from bytes 1 and 2 of every packet, looks up its bit, and either forwards the whole packet or removes it. A packet is never cut short at the output.

A host reaches both maps through three byte-wide indirect registers: a low address, a high address that also selects the map, and a data window onto the addressed byte. To change one flag, the host reads the byte, changes the bit and writes the byte back. Host accesses use a separate table port, so they never hold up either stream.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset every map byte reads 0xFF, both address registers read 0x00, and no packet is forwarded on either lane.
- R2: Host select 0 is the low address register and holds PID bits 10:3. Select 1 is the high address register: bits 1:0 hold PID bits 12:11, bit 2 picks map 0 or map 1, and bits 7:3 read as 0. Select 2 is the data window onto the addressed map byte. Select 3 reads 0x00 and ignores writes.
- R3: In a map byte, bit position PID[2:0] is the flag for that PID. A flag of 1 drops packets with that PID and a flag of 0 passes them. A map filled with 0x00 passes every PID.
- R4: Lane 0 consults only map 0 and lane 1 consults only map 1.
- R5: A packet is 188 bytes on consecutive valid cycles, with s_sop_i raised on byte 0. Its PID is byte 1 bits 4:0 followed by byte 2, so byte 1 bits 7:5 are ignored. A forwarded packet leaves unchanged, every byte 3 cycles after it entered, with m_sop_o on byte 0 and m_eop_o on byte 187. Packets may follow one another with no gap.
- R6: A packet whose byte 0 is not 0x47 is discarded whole, whatever its flag.
- R7: Valid bytes that arrive outside a packet (after byte 187 and before the next s_sop_i) are ignored and produce no output.
- R8: A byte written through the data window reads back through the data window on the next cycle.
- R9: A lane uses the flag as it stands in the cycle that byte 2 arrives. A host write during a packet does not stall the stream and does not change the fate of a packet whose byte 2 has already been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 2 | Host register select |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data of the selected register |
| s_valid_i | input | 2 | Input byte valid, one bit per lane |
| s_sop_i | input | 2 | Input packet start, one bit per lane |
| s_data_i | input | 16 | Input bytes, lane n in bits 8n+7:8n |
| m_valid_o | output | 2 | Output byte valid, per lane |
| m_sop_o | output | 2 | Output packet start, per lane |
| m_eop_o | output | 2 | Output packet end, per lane |
| m_data_o | output | 16 | Output bytes, lane n in bits 8n+7:8n |

## Verification
The hardest case to reach is a host write that lands while a packet is streaming and flips that packet's own flag. The packet must still arrive whole, and only the next packet may feel the change. The bench forks a host read-modify-write twenty cycles into a passing packet, then sends the same PID again and expects it to be dropped. Back-to-back packets with alternating verdicts check that a verdict switches exactly at a packet boundary. Stray bytes that look like a header but carry no start marker check that a lane stays idle between packets.

// File: rtl/pid_filter_pkg.sv
package pid_filter_pkg;
  localparam int PID_W    = 13;
  localparam int BIT_W    = 3;
  localparam int ROW_W    = PID_W - BIT_W;
  localparam int PKT_LEN  = 188;
  localparam int IDX_W    = $clog2(PKT_LEN + 1);
  localparam int DLY      = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic       valid;
    logic       sop;
    logic       eop;
    logic [7:0] data;
  } beat_t;
endpackage

// File: rtl/pid_table.sv
module pid_table
  import pid_filter_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int FSEL_W = $clog2(NUM_CH),
  localparam int ADDR_W = FSEL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [ROW_W-1:0]  lk_row_i  [NUM_CH],
  output logic [7:0]        lk_byte_o [NUM_CH]
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0] mem_q [DEPTH];

  // reset value 0xFF: every PID blocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lookup
    assign lk_byte_o[c] = mem_q[{FSEL_W'(c), lk_row_i[c]}];
  end
endmodule

// File: rtl/ts_lane.sv
module ts_lane
  import pid_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic [7:0]       data_i,
  output logic [ROW_W-1:0] row_o,
  input  logic [7:0]       row_byte_i,
  output logic             m_valid_o,
  output logic             m_sop_o,
  output logic             m_eop_o,
  output logic [7:0]       m_data_o
);
  localparam int HI_W = PID_W - 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic             active_q, sync_ok_q, keep_q, accept;
  logic [IDX_W-1:0] idx_q, pos;
  logic [HI_W-1:0]  pid_hi_q;
  logic [PID_W-1:0] pid;
  beat_t            pipe_q [DLY];

  assign pos    = sop_i ? '0 : idx_q;
  assign accept = valid_i && (sop_i || active_q);
  assign pid    = {pid_hi_q, data_i};
  assign row_o  = pid[PID_W-1:BIT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      idx_q     <= '0;
      sync_ok_q <= 1'b0;
      keep_q    <= 1'b0;
      pid_hi_q  <= '0;
      for (int k = 0; k < DLY; k++) pipe_q[k] <= '0;
    end else begin
      if (accept) begin
        active_q <= (pos != LAST);
        idx_q    <= pos + 1'b1;
        if (pos == IDX_W'(0)) sync_ok_q <= (data_i == SYNC_BYTE);
        if (pos == IDX_W'(1)) pid_hi_q  <= data_i[HI_W-1:0];
        // verdict lands exactly when byte 0 reaches the last stage
        if (pos == IDX_W'(2)) keep_q    <= sync_ok_q & ~row_byte_i[pid[BIT_W-1:0]];
      end
      pipe_q[0] <= '{valid: accept,
                     sop:   accept && (pos == IDX_W'(0)),
                     eop:   accept && (pos == LAST),
                     data:  data_i};
      for (int k = 1; k < DLY; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign m_valid_o = pipe_q[DLY-1].valid & keep_q;
  assign m_sop_o   = pipe_q[DLY-1].sop   & m_valid_o;
  assign m_eop_o   = pipe_q[DLY-1].eop   & m_valid_o;
  assign m_data_o  = pipe_q[DLY-1].data;

  // R6: a forwarded packet always opens with the sync byte
  a_r6_sop_is_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_sop_o |-> (m_data_o == SYNC_BYTE));

  // R5: output never starts in the middle of a packet
  a_r5_start_on_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_valid_o) |-> m_sop_o);

  // R5: after the last byte comes either silence or a new packet
  a_r5_after_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_eop_o |=> (!m_valid_o || m_sop_o));
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import pid_filter_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          host_sel_i,
  input  logic                host_we_i,
  input  logic [7:0]          host_wdata_i,
  output logic [7:0]          host_rdata_o,
  input  logic [NUM_CH-1:0]   s_valid_i,
  input  logic [NUM_CH-1:0]   s_sop_i,
  input  logic [NUM_CH*8-1:0] s_data_i,
  output logic [NUM_CH-1:0]   m_valid_o,
  output logic [NUM_CH-1:0]   m_sop_o,
  output logic [NUM_CH-1:0]   m_eop_o,
  output logic [NUM_CH*8-1:0] m_data_o
);
  localparam int FSEL_W = $clog2(NUM_CH);
  localparam int HI_W   = FSEL_W + ROW_W - 8;
  localparam int ADDR_W = FSEL_W + ROW_W;

  logic [7:0]       lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [7:0]       tbl_rdata;
  logic             tbl_we;
  logic [ROW_W-1:0] lk_row  [NUM_CH];
  logic [7:0]       lk_byte [NUM_CH];

  assign tbl_we = host_we_i && (host_sel_i == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (host_we_i) begin
      if (host_sel_i == SEL_LO) lo_q <= host_wdata_i;
      if (host_sel_i == SEL_HI) hi_q <= host_wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    unique case (host_sel_e'(host_sel_i))
      SEL_LO:   host_rdata_o = lo_q;
      SEL_HI:   host_rdata_o = 8'(hi_q);
      SEL_DATA: host_rdata_o = tbl_rdata;
      default:  host_rdata_o = 8'h00;
    endcase
  end

  pid_table #(.NUM_CH(NUM_CH)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we),
    .addr_i    (ADDR_W'({hi_q, lo_q})),
    .wdata_i   (host_wdata_i),
    .rdata_o   (tbl_rdata),
    .lk_row_i  (lk_row),
    .lk_byte_o (lk_byte)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ts_lane u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (s_valid_i[c]),
      .sop_i      (s_sop_i[c]),
      .data_i     (s_data_i[c*8 +: 8]),
      .row_o      (lk_row[c]),
      .row_byte_i (lk_byte[c]),
      .m_valid_o  (m_valid_o[c]),
      .m_sop_o    (m_sop_o[c]),
      .m_eop_o    (m_eop_o[c]),
      .m_data_o   (m_data_o[c*8 +: 8])
    );
  end

  // R8: a byte written through the window is what the window shows next
  a_r8_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |=> (tbl_rdata == $past(host_wdata_i)));
endmodule

// File: tb/tb_ts_pid_filter.sv
`timescale 1ns/1ps
module tb_ts_pid_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic [1:0]  s_valid = '0, s_sop = '0;
  logic [15:0] s_data = '0;
  logic [1:0]  m_valid, m_sop, m_eop;
  logic [15:0] m_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] got0[$], got1[$];
  int pos0 = 0, pos1 = 0, frame_err = 0;

  always #4 clk = ~clk;

  ts_pid_filter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(host_sel), .host_we_i(host_we),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .s_valid_i(s_valid), .s_sop_i(s_sop), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_sop_o(m_sop), .m_eop_o(m_eop), .m_data_o(m_data)
  );

  // output monitor: collects bytes and checks framing positions
  always @(negedge clk) begin
    if (rst_n && m_valid[0]) begin
      got0.push_back(m_data[7:0]);
      if (m_sop[0] != (pos0 == 0) || m_eop[0] != (pos0 == 187)) frame_err++;
      pos0 = (pos0 == 187) ? 0 : pos0 + 1;
    end
    if (rst_n && m_valid[1]) begin
      got1.push_back(m_data[15:8]);
      if (m_sop[1] != (pos1 == 0) || m_eop[1] != (pos1 == 187)) frame_err++;
      pos1 = (pos1 == 187) ? 0 : pos1 + 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(int i, int pid, int sync, int tag);
    if (i == 0) return 8'(sync);
    if (i == 1) return {3'b010, 5'(pid >> 8)};
    if (i == 2) return 8'(pid);
    return 8'(i + tag);
  endfunction

  task automatic host_wr(int sel, int d);
    @(negedge clk);
    host_sel = 2'(sel); host_wdata = 8'(d); host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(int sel, output int d);
    @(negedge clk);
    host_sel = 2'(sel); host_we = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic set_entry(int filt, int pid, bit drop, string req);
    int b, rb;
    host_wr(0, (pid >> 3) & 8'hFF);
    host_wr(1, (filt << 2) | ((pid >> 11) & 3));
    host_rd(2, b);
    if (drop) b = b | (1 << (pid & 7));
    else      b = b & ~(1 << (pid & 7));
    host_wr(2, b);
    host_rd(2, rb);
    chk(req, "R8 data window readback", rb, b);
  endtask

  task automatic send_pkt(int ch, int pid, int sync, int tag);
    for (int i = 0; i < 188; i++) begin
      @(negedge clk);
      s_valid[ch] = 1'b1;
      s_sop[ch]   = (i == 0);
      s_data[ch*8 +: 8] = pkt_byte(i, pid, sync, tag);
    end
  endtask

  task automatic idle(int ch);
    @(negedge clk);
    s_valid[ch] = 1'b0; s_sop[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_out();
    got0.delete(); got1.delete(); pos0 = 0; pos1 = 0; frame_err = 0;
  endtask

  task automatic check_out(int ch, int npk, int pid, int tag, string req);
    int n;
    n = (ch == 0) ? got0.size() : got1.size();
    chk(req, $sformatf("lane%0d byte count", ch), n, 188 * npk);
    chk(req, "R5 framing", frame_err, 0);
    if (n == 188 * npk && npk > 0) begin
      for (int i = 0; i < 188; i += 1) begin
        if (i < 4 || i == 100 || i == 187) begin
          chk(req, $sformatf("R5 lane%0d byte %0d", ch, i),
              (ch == 0) ? got0[i] : got1[i], pkt_byte(i, pid, 8'h47, tag));
        end
      end
    end
  endtask

  task automatic run_pkt(int ch, int pid, int sync, int tag, bit pass, string req);
    clear_out();
    send_pkt(ch, pid, sync, tag);
    idle(ch);
    check_out(ch, pass ? 1 : 0, pid, tag, req);
  endtask

  task automatic t_reset();
    int d;
    host_rd(0, d); chk("R1", "low addr after reset", d, 0);
    host_rd(1, d); chk("R1", "high addr after reset", d, 0);
    host_rd(2, d); chk("R1", "map byte after reset", d, 8'hFF);
    run_pkt(0, 13'h0100, 8'h47, 1, 1'b0, "R1");
    run_pkt(1, 13'h1FFF, 8'h47, 2, 1'b0, "R1");
  endtask

  task automatic t_host_regs();
    int d;
    host_wr(0, 8'hA5); host_rd(0, d); chk("R2", "low addr readback", d, 8'hA5);
    host_wr(1, 8'hFF); host_rd(1, d); chk("R2", "high addr masks bits 7:3", d, 8'h07);
    host_wr(3, 8'h5A); host_rd(3, d); chk("R2", "select 3 reads zero", d, 0);
    host_rd(0, d); chk("R2", "select 3 write ignored", d, 8'hA5);
    host_wr(0, 0); host_wr(1, 0);
  endtask

  task automatic t_flag_bit();
    set_entry(0, 13'h1234, 1'b0, "R3");
    run_pkt(0, 13'h1234, 8'h47, 9, 1'b1, "R3");
    run_pkt(0, 13'h1235, 8'h47, 9, 1'b0, "R3");
    run_pkt(1, 13'h1234, 8'h47, 9, 1'b0, "R4");
  endtask

  task automatic t_channels();
    set_entry(1, 13'h0011, 1'b0, "R4");
    run_pkt(1, 13'h0011, 8'h47, 3, 1'b1, "R4");
    run_pkt(0, 13'h0011, 8'h47, 3, 1'b0, "R4");
  endtask

  task automatic t_bad_sync();
    run_pkt(0, 13'h1234, 8'h46, 4, 1'b0, "R6");
    run_pkt(0, 13'h1234, 8'h47, 4, 1'b1, "R6");
  endtask

  task automatic t_stray();
    clear_out();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      s_valid[0] = 1'b1; s_sop[0] = 1'b0;
      s_data[7:0] = (i == 0) ? 8'h47 : (i == 1) ? 8'h12 : (i == 2) ? 8'h34 : 8'(i);
    end
    idle(0);
    chk("R7", "stray bytes produce no output", got0.size(), 0);
  endtask

  task automatic t_back_to_back();
    clear_out();
    send_pkt(0, 13'h1234, 8'h47, 5);
    send_pkt(0, 13'h1235, 8'h47, 6);
    send_pkt(0, 13'h1234, 8'h47, 5);
    idle(0);
    chk("R5", "back-to-back pass/drop/pass byte count", got0.size(), 376);
    chk("R5", "back-to-back framing", frame_err, 0);
    if (got0.size() == 376) begin
      chk("R5", "second kept packet sync", got0[188], 8'h47);
      chk("R5", "second kept packet last byte", got0[375], pkt_byte(187, 13'h1234, 8'h47, 5));
    end
  endtask

  task automatic t_concurrent();
    clear_out();
    fork
      send_pkt(0, 13'h1234, 8'h47, 7);
      begin
        repeat (20) @(negedge clk);
        set_entry(0, 13'h1234, 1'b1, "R9");
        set_entry(1, 13'h0777, 1'b0, "R9");
      end
    join
    idle(0);
    check_out(0, 1, 13'h1234, 7, "R9");
    run_pkt(0, 13'h1234, 8'h47, 7, 1'b0, "R9");
  endtask

  task automatic t_open_map();
    for (int r = 0; r < 1024; r++) begin
      host_wr(0, r & 8'hFF);
      host_wr(1, 4 | (r >> 8));
      host_wr(2, 0);
    end
    run_pkt(1, 13'h1FFF, 8'h47, 8, 1'b1, "R3");
    run_pkt(1, 13'h0000, 8'h47, 8, 1'b1, "R3");
    run_pkt(0, 13'h1FFF, 8'h47, 8, 1'b0, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_regs();
    t_flag_bit();
    t_channels();
    t_bad_sync();
    t_stray();
    t_back_to_back();
    t_concurrent();
    t_open_map();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule